// File: doc/BRIEF.md
# In-Order Four-Wide Instruction Queue and Dispatcher

This block sits between instruction fetch and the execution pipes of a superscalar core. Fetch hands it a group of four partially decoded instructions at once; the group is written into a six-entry circular queue. Every cycle the dispatcher looks at the four oldest queued entries and issues a prefix of them (zero to four) toward the integer, floating-point and memory pipes. Issued entries leave the queue at the next clock edge.

The dispatcher stops at the first entry that cannot go. An entry is held when its class would exceed the per-cycle mix limits, when the resource it needs is reported busy, or when it reads or overwrites a register that an older entry issuing in the same cycle writes. Fetch is throttled so that a whole group always fits, and a flush empties the queue in one cycle.

Top module: `iq_dispatch`

## Requirements
- R1: After reset the queue is empty: `fetch_ready` is 1, `issue_valid` is 0 and `deq_count` is 0.
- R2: `fetch_ready` is 1 exactly when at least four entries are free. A group offered with `fetch_valid` while `fetch_ready` is 1 is written whole, lane 0 oldest, behind the entries already queued; a group offered while `fetch_ready` is 0 is dropped. Slot k of `issue_tag`/`issue_cls` shows the k-th oldest queued entry whether or not it issues.
- R3: Issue is in program order: slot k issues only if slots 0..k-1 issue. `deq_count` equals the number of issued slots, and exactly those entries leave the queue at the next edge.
- R4: Class codes are 0 integer ALU, 1 integer multiply, 2 branch, 3 FP operation, 4 integer load, 5 integer store, 6 FP load, 7 FP store. Codes 0..2 are integer class; at most two integer-class entries issue per cycle, of which at most one multiply and at most one branch.
- R5: At most two FP-operation entries (code 3) issue per cycle.
- R6: At most two memory entries (codes 4..7) issue per cycle in any mix, except that two integer stores never issue together.
- R7: `unit_busy` bit 0 holds ALU entries, bit 1 multiply, bit 2 branch, bit 3 FP operations, bit 4 all memory entries; a held entry blocks every younger slot.
- R8: An entry is held if an older entry issuing in the same cycle has its destination enable set and its destination equals either of the entry's sources or, when the entry's own destination enable is set, its destination. A destination with enable clear creates no dependence.
- R9: While `flush` is 1 nothing issues and any offered group is dropped; the queue is empty in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue, suppress issue this cycle |
| fetch_valid | input | 1 | A fetch group is offered |
| fetch_tag | input | 32 | Per-lane opaque tag, 8 bits per lane |
| fetch_cls | input | 12 | Per-lane class code, 3 bits per lane |
| fetch_dst | input | 20 | Per-lane destination register, 5 bits per lane |
| fetch_dst_en | input | 4 | Per-lane destination write enable |
| fetch_src_a | input | 20 | Per-lane first source register |
| fetch_src_b | input | 20 | Per-lane second source register |
| unit_busy | input | 5 | Per-resource busy flags (ALU, MUL, BR, FP, MEM) |
| fetch_ready | output | 1 | Queue can take a whole group this cycle |
| issue_valid | output | 4 | Per-slot issue strobe, slot 0 oldest |
| issue_tag | output | 32 | Tag of the entry in each slot |
| issue_cls | output | 12 | Class of the entry in each slot |
| deq_count | output | 3 | Number of entries issued this cycle |

## Verification
Hand-built groups are loaded with every resource busy, then released so the issue mask is read combinationally without draining; each group isolates one rule: an integer overflow at slot 2, paired multiplies or branches, a third FP operation, paired integer stores versus a legal store mix, a single busy resource, and read-after-write, write-after-write and disabled-destination cases that separate a true dependence from a register-number coincidence. A directed refill sequence distinguishes a dropped group from an accepted one and checks that new lanes land behind the survivors of a partial dequeue. A long pseudo-random sweep over a narrow register range, with random busy flags, fetch and occasional flushes, compares every cycle against a queue model kept in the bench.

// File: rtl/iqd_pkg.sv
// Shared types for the instruction queue and dispatcher.
// Assumes a 3-bit class code whose values are decoded by the selector and checker.
package iqd_pkg;
    localparam int TAG_W   = 8;
    localparam int REG_W   = 5;
    localparam int CLS_W   = 3;
    localparam int NUM_RES = 5;

    // Resource indices into the busy vector
    localparam int RES_ALU = 0;
    localparam int RES_MUL = 1;
    localparam int RES_BR  = 2;
    localparam int RES_FP  = 3;
    localparam int RES_MEM = 4;

    typedef enum logic [CLS_W-1:0] {
        C_ALU = 3'd0,
        C_MUL = 3'd1,
        C_BR  = 3'd2,
        C_FP  = 3'd3,
        C_ILD = 3'd4,
        C_IST = 3'd5,
        C_FLD = 3'd6,
        C_FST = 3'd7
    } iclass_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        iclass_e          cls;
        logic [REG_W-1:0] dst;
        logic             dst_en;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
    } instr_t;

    // True for the three integer-pipe classes
    function automatic logic is_int_cls(input iclass_e c);
        return (c == C_ALU) || (c == C_MUL) || (c == C_BR);
    endfunction

    // True for loads and stores of either register file
    function automatic logic is_mem_cls(input iclass_e c);
        return (c == C_ILD) || (c == C_IST) || (c == C_FLD) || (c == C_FST);
    endfunction
endpackage

// File: rtl/iqd_queue.sv
// Circular instruction store with DEPTH entries. Writes a whole group of
// GROUP entries behind the tail and presents the GROUP oldest entries as
// read slots. Assumes the caller only asserts enq when DEPTH-count >= GROUP
// and never dequeues more than the valid slots.
module iqd_queue
    import iqd_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int GROUP = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int DQ_W  = $clog2(GROUP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  enq,
    input  instr_t [GROUP-1:0]    enq_group,
    input  logic [DQ_W-1:0]       deq_cnt,
    output instr_t [GROUP-1:0]    slot,
    output logic [GROUP-1:0]      slot_valid,
    output logic [OCC_W-1:0]      occupancy
);
    instr_t              store [DEPTH];
    logic [PTR_W-1:0]    head;
    logic [OCC_W-1:0]    count;

    // Reduce a small non-negative sum to a queue index
    function automatic logic [PTR_W-1:0] wrap(input int v);
        return PTR_W'(v % DEPTH);
    endfunction

    // Write the incoming group behind the current tail
    always_ff @(posedge clk) begin
        if (enq && !flush) begin
            for (int g = 0; g < GROUP; g++) begin
                store[wrap(int'(head) + int'(count) + g)] <= enq_group[g];
            end
        end
    end

    // Advance head and occupancy; flush empties in one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else if (flush) begin
            head  <= '0;
            count <= '0;
        end else begin
            head  <= wrap(int'(head) + int'(deq_cnt));
            count <= OCC_W'(int'(count) + (enq ? GROUP : 0) - int'(deq_cnt));
        end
    end

    // Present the oldest entries as issue slots
    always_comb begin
        for (int k = 0; k < GROUP; k++) begin
            slot[k]       = store[wrap(int'(head) + k)];
            slot_valid[k] = count > OCC_W'(k);
        end
    end

    assign occupancy = count;
endmodule

// File: rtl/iqd_select.sv
// Issue selector: walks the slots oldest first and issues the longest
// prefix that respects the class-mix limits, the busy flags and the
// in-window register dependences. Assumes slot 0 is the oldest entry.
module iqd_select
    import iqd_pkg::*;
#(
    parameter int GROUP   = 4,
    parameter int MAX_INT = 2,
    parameter int MAX_FP  = 2,
    parameter int MAX_MEM = 2,
    localparam int DQ_W   = $clog2(GROUP + 1)
) (
    input  instr_t [GROUP-1:0]   slot,
    input  logic [GROUP-1:0]     slot_valid,
    input  logic [NUM_RES-1:0]   busy,
    input  logic                 flush,
    output logic [GROUP-1:0]     issue,
    output logic [DQ_W-1:0]      deq_cnt
);
    // Prefix walk with running per-class counters
    always_comb begin
        int   n_int;
        int   n_fp;
        int   n_mem;
        int   n_mul;
        int   n_br;
        int   n_ist;
        logic open;
        logic take;
        n_int = 0;
        n_fp  = 0;
        n_mem = 0;
        n_mul = 0;
        n_br  = 0;
        n_ist = 0;
        open  = 1'b1;
        take  = 1'b0;
        issue = '0;
        for (int k = 0; k < GROUP; k++) begin
            take = open && slot_valid[k] && !flush;
            if (is_int_cls(slot[k].cls)) begin
                if (n_int >= MAX_INT) take = 1'b0;
            end
            unique case (slot[k].cls)
                C_ALU: if (busy[RES_ALU]) take = 1'b0;
                C_MUL: if (busy[RES_MUL] || n_mul >= 1) take = 1'b0;
                C_BR:  if (busy[RES_BR] || n_br >= 1) take = 1'b0;
                C_FP:  if (busy[RES_FP] || n_fp >= MAX_FP) take = 1'b0;
                C_IST: if (busy[RES_MEM] || n_mem >= MAX_MEM || n_ist >= 1) take = 1'b0;
                default: if (busy[RES_MEM] || n_mem >= MAX_MEM) take = 1'b0;
            endcase
            for (int j = 0; j < k; j++) begin
                if (slot[j].dst_en &&
                    ((slot[j].dst == slot[k].src_a) ||
                     (slot[j].dst == slot[k].src_b) ||
                     (slot[k].dst_en && slot[j].dst == slot[k].dst))) begin
                    take = 1'b0;
                end
            end
            if (take) begin
                issue[k] = 1'b1;
                if (is_int_cls(slot[k].cls)) n_int++;
                if (is_mem_cls(slot[k].cls)) n_mem++;
                if (slot[k].cls == C_FP)  n_fp++;
                if (slot[k].cls == C_MUL) n_mul++;
                if (slot[k].cls == C_BR)  n_br++;
                if (slot[k].cls == C_IST) n_ist++;
            end else begin
                open = 1'b0;
            end
        end
    end

    // Number of entries leaving the queue
    assign deq_cnt = DQ_W'($countones(issue));
endmodule

// File: rtl/iq_dispatch.sv
// Top of the instruction queue and dispatcher. Unpacks the flat fetch
// lanes into entries, throttles fetch so a group is taken whole, and
// exposes the selector's per-slot strobes and slot contents.
// Assumes fetch holds an offered group until it sees fetch_ready.
module iq_dispatch
    import iqd_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int GROUP   = 4,
    parameter int MAX_INT = 2,
    parameter int MAX_FP  = 2,
    parameter int MAX_MEM = 2,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int DQ_W   = $clog2(GROUP + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      fetch_valid,
    input  logic [GROUP*TAG_W-1:0]    fetch_tag,
    input  logic [GROUP*CLS_W-1:0]    fetch_cls,
    input  logic [GROUP*REG_W-1:0]    fetch_dst,
    input  logic [GROUP-1:0]          fetch_dst_en,
    input  logic [GROUP*REG_W-1:0]    fetch_src_a,
    input  logic [GROUP*REG_W-1:0]    fetch_src_b,
    input  logic [NUM_RES-1:0]        unit_busy,
    output logic                      fetch_ready,
    output logic [GROUP-1:0]          issue_valid,
    output logic [GROUP*TAG_W-1:0]    issue_tag,
    output logic [GROUP*CLS_W-1:0]    issue_cls,
    output logic [DQ_W-1:0]           deq_count
);
    instr_t [GROUP-1:0]  grp;
    instr_t [GROUP-1:0]  slot;
    logic [GROUP-1:0]    slot_valid;
    logic [OCC_W-1:0]    occupancy;
    logic                enq;

    // Per-lane pack of the fetch group and unpack of the slots
    for (genvar g = 0; g < GROUP; g++) begin : g_lane
        assign grp[g].tag    = fetch_tag[g*TAG_W +: TAG_W];
        assign grp[g].cls    = iclass_e'(fetch_cls[g*CLS_W +: CLS_W]);
        assign grp[g].dst    = fetch_dst[g*REG_W +: REG_W];
        assign grp[g].dst_en = fetch_dst_en[g];
        assign grp[g].src_a  = fetch_src_a[g*REG_W +: REG_W];
        assign grp[g].src_b  = fetch_src_b[g*REG_W +: REG_W];
        assign issue_tag[g*TAG_W +: TAG_W] = slot[g].tag;
        assign issue_cls[g*CLS_W +: CLS_W] = slot[g].cls;
    end

    // Accept only when a whole group fits
    assign fetch_ready = occupancy <= OCC_W'(DEPTH - GROUP);
    assign enq         = fetch_valid && fetch_ready && !flush;

    iqd_queue #(
        .DEPTH (DEPTH),
        .GROUP (GROUP)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .enq        (enq),
        .enq_group  (grp),
        .deq_cnt    (deq_count),
        .slot       (slot),
        .slot_valid (slot_valid),
        .occupancy  (occupancy)
    );

    iqd_select #(
        .GROUP   (GROUP),
        .MAX_INT (MAX_INT),
        .MAX_FP  (MAX_FP),
        .MAX_MEM (MAX_MEM)
    ) u_select (
        .slot       (slot),
        .slot_valid (slot_valid),
        .busy       (unit_busy),
        .flush      (flush),
        .issue      (issue_valid),
        .deq_cnt    (deq_count)
    );
endmodule

// File: rtl/iqd_chk.sv
// Property checker for iq_dispatch, attached by bind. Decodes the issued
// classes from the slot outputs and checks mix limits, ordering, occupancy
// accounting and flush behaviour.
module iqd_chk
    import iqd_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int GROUP   = 4,
    parameter int MAX_INT = 2,
    parameter int MAX_FP  = 2,
    parameter int MAX_MEM = 2,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int DQ_W   = $clog2(GROUP + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic                    fetch_valid,
    input logic                    fetch_ready,
    input logic [GROUP-1:0]        issue_valid,
    input logic [GROUP*CLS_W-1:0]  issue_cls,
    input logic [DQ_W-1:0]         deq_count,
    input logic [OCC_W-1:0]        occupancy
);
    logic [GROUP-1:0] v_int, v_fp, v_mem, v_ist;

    // Classify each issued slot
    for (genvar k = 0; k < GROUP; k++) begin : g_cls
        logic [CLS_W-1:0] c;
        assign c        = issue_cls[k*CLS_W +: CLS_W];
        assign v_int[k] = issue_valid[k] && (c <= 3'd2);
        assign v_fp[k]  = issue_valid[k] && (c == 3'd3);
        assign v_mem[k] = issue_valid[k] && (c >= 3'd4);
        assign v_ist[k] = issue_valid[k] && (c == 3'd5);
    end

    // R3
    for (genvar k = 0; k < GROUP - 1; k++) begin : g_ord
        in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[k+1] |-> issue_valid[k]);
    end

    // R3
    occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> int'(occupancy) == int'($past(occupancy))
                   + ($past(fetch_valid && fetch_ready) ? GROUP : 0)
                   - int'($past(deq_count)));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    // R4
    int_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(v_int) <= MAX_INT);

    // R5
    fp_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(v_fp) <= MAX_FP);

    // R6
    mem_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(v_mem) <= MAX_MEM);

    // R6
    one_int_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(v_ist));

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> issue_valid == '0);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> occupancy == '0);
endmodule

bind iq_dispatch iqd_chk #(
    .DEPTH   (DEPTH),
    .GROUP   (GROUP),
    .MAX_INT (MAX_INT),
    .MAX_FP  (MAX_FP),
    .MAX_MEM (MAX_MEM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .issue_valid (issue_valid),
    .issue_cls   (issue_cls),
    .deq_count   (deq_count),
    .occupancy   (occupancy)
);

// File: tb/iq_dispatch_test.sv
module iq_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_tag = '0;
    logic [11:0] fetch_cls = '0;
    logic [19:0] fetch_dst = '0;
    logic [3:0]  fetch_dst_en = '0;
    logic [19:0] fetch_src_a = '0;
    logic [19:0] fetch_src_b = '0;
    logic [4:0]  unit_busy = 5'h1F;
    logic        fetch_ready;
    logic [3:0]  issue_valid;
    logic [31:0] issue_tag;
    logic [11:0] issue_cls;
    logic [2:0]  deq_count;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int tag_base = 16;

    // bench-side queue model, index 0 oldest
    int q_n = 0;
    int q_tag[6], q_cls[6], q_dst[6], q_den[6], q_sa[6], q_sb[6];

    iq_dispatch uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
        .fetch_tag(fetch_tag), .fetch_cls(fetch_cls), .fetch_dst(fetch_dst),
        .fetch_dst_en(fetch_dst_en), .fetch_src_a(fetch_src_a),
        .fetch_src_b(fetch_src_b), .unit_busy(unit_busy),
        .fetch_ready(fetch_ready), .issue_valid(issue_valid),
        .issue_tag(issue_tag), .issue_cls(issue_cls), .deq_count(deq_count)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_slot(input int k, input int c, input int d, input int de,
                            input int a, input int b);
        fetch_cls[k*3 +: 3]   = 3'(c);
        fetch_dst[k*5 +: 5]   = 5'(d);
        fetch_dst_en[k]       = 1'(de);
        fetch_src_a[k*5 +: 5] = 5'(a);
        fetch_src_b[k*5 +: 5] = 5'(b);
        fetch_tag[k*8 +: 8]   = 8'(tag_base + k);
    endtask

    // four lanes with disjoint registers
    task automatic set4(input int c0, input int c1, input int c2, input int c3);
        set_slot(0, c0, 8, 1, 16, 24);
        set_slot(1, c1, 9, 1, 17, 25);
        set_slot(2, c2, 10, 1, 18, 26);
        set_slot(3, c3, 11, 1, 19, 27);
    endtask

    // load one group with all pipes busy, then release and read the mask
    task automatic pattern(input string req, input logic [4:0] bz, input logic [3:0] exp);
        @(negedge clk); flush = 1'b1; fetch_valid = 1'b0; unit_busy = 5'h1F;
        @(negedge clk); flush = 1'b0; fetch_valid = 1'b1;
        @(negedge clk); fetch_valid = 1'b0; unit_busy = bz;
        #1;
        check(req, "issue_valid", 32'(issue_valid), 32'(exp));
        check(req, "deq_count", 32'(deq_count), 32'($countones(exp)));
        check(req, "slot0 tag", 32'(issue_tag[7:0]), 32'(tag_base[7:0]));
        unit_busy = 5'h1F;
        tag_base += 4;
    endtask

    function automatic logic [3:0] model_issue(input logic [4:0] bz, input logic fl);
        logic [3:0] m = '0;
        logic open = 1'b1;
        int ni = 0, nf = 0, nm = 0, nmul = 0, nbr = 0, nist = 0;
        for (int k = 0; k < 4; k++) begin
            logic can;
            int c;
            can = open && (k < q_n) && !fl;
            c = q_cls[k];
            if (c <= 2 && (ni >= 2 || bz[c])) can = 1'b0;
            if (c == 1 && nmul >= 1) can = 1'b0;
            if (c == 2 && nbr >= 1) can = 1'b0;
            if (c == 3 && (nf >= 2 || bz[3])) can = 1'b0;
            if (c >= 4 && (nm >= 2 || bz[4])) can = 1'b0;
            if (c == 5 && nist >= 1) can = 1'b0;
            for (int j = 0; j < k; j++)
                if (q_den[j] != 0 && (q_dst[j] == q_sa[k] || q_dst[j] == q_sb[k] ||
                    (q_den[k] != 0 && q_dst[j] == q_dst[k]))) can = 1'b0;
            if (can) begin
                m[k] = 1'b1;
                if (c <= 2) ni++;
                if (c == 1) nmul++;
                if (c == 2) nbr++;
                if (c == 3) nf++;
                if (c >= 4) nm++;
                if (c == 5) nist++;
            end else open = 1'b0;
        end
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        unit_busy = 5'h00;
        #1;
        // R1 reset state
        check("R1", "fetch_ready", 32'(fetch_ready), 32'd1);
        check("R1", "issue_valid", 32'(issue_valid), 32'd0);
        check("R1", "deq_count", 32'(deq_count), 32'd0);

        // R4 integer limits
        set4(0, 0, 0, 3); pattern("R4 alu x3", 5'h00, 4'b0011);
        set4(1, 1, 3, 3); pattern("R4 mul pair", 5'h00, 4'b0001);
        set4(2, 0, 2, 3); pattern("R4 branch pair", 5'h00, 4'b0011);
        // R5 FP limit
        set4(3, 3, 3, 0); pattern("R5 fp x3", 5'h00, 4'b0011);
        set4(3, 0, 3, 4); pattern("R5 legal mix", 5'h00, 4'b1111);
        // R6 memory limit and integer store pair
        set4(4, 6, 7, 0); pattern("R6 mem x3", 5'h00, 4'b0011);
        set4(5, 5, 3, 3); pattern("R6 istore pair", 5'h00, 4'b0001);
        set4(5, 7, 0, 3); pattern("R6 store mix", 5'h00, 4'b1111);
        // R7 busy resources
        set4(0, 3, 0, 0); pattern("R7 fp busy", 5'h08, 4'b0001);
        set4(4, 0, 0, 3); pattern("R7 mem busy", 5'h10, 4'b0000);
        set4(0, 1, 2, 3); pattern("R7 mul busy", 5'h02, 4'b0001);
        // R8 dependences
        set4(0, 0, 3, 3); set_slot(0, 0, 3, 1, 16, 24); set_slot(1, 0, 9, 1, 3, 25);
        pattern("R8 raw", 5'h00, 4'b0001);
        set4(0, 3, 3, 4); set_slot(0, 0, 5, 1, 16, 24); set_slot(1, 3, 5, 1, 17, 25);
        pattern("R8 waw", 5'h00, 4'b0001);
        set4(0, 3, 3, 4); set_slot(0, 0, 3, 0, 16, 24); set_slot(1, 3, 9, 1, 3, 25);
        pattern("R8 dst disabled", 5'h00, 4'b1111);
        set4(3, 3, 0, 0); set_slot(0, 3, 7, 1, 16, 24); set_slot(2, 0, 10, 1, 18, 7);
        pattern("R8 src_b raw", 5'h00, 4'b0011);

        // R2 / R3 refill sequence
        set4(0, 0, 0, 0); pattern("R4 alu x4", 5'h00, 4'b0011);
        check("R2", "ready with 4 queued", 32'(fetch_ready), 32'd0);
        set4(3, 3, 4, 4); // tags 0x..+0..3 of the new group
        @(negedge clk); fetch_valid = 1'b1;
        @(negedge clk); fetch_valid = 1'b0; #1;
        check("R2", "dropped group slot3 tag", 32'(issue_tag[31:24]), 32'(tag_base - 4 + 3));
        unit_busy = 5'h00;
        @(negedge clk); unit_busy = 5'h1F; #1;
        check("R2", "ready with 2 queued", 32'(fetch_ready), 32'd1);
        check("R3", "head after dequeue", 32'(issue_tag[7:0]), 32'(tag_base - 4 + 2));
        fetch_valid = 1'b1;
        @(negedge clk); fetch_valid = 1'b0; #1;
        check("R2", "slot1 tag", 32'(issue_tag[15:8]), 32'(tag_base - 4 + 3));
        check("R2", "slot2 tag", 32'(issue_tag[23:16]), 32'(tag_base));
        check("R2", "slot3 tag", 32'(issue_tag[31:24]), 32'(tag_base + 1));
        check("R2", "ready when full", 32'(fetch_ready), 32'd0);

        // R9 flush
        unit_busy = 5'h00; flush = 1'b1; fetch_valid = 1'b1; #1;
        check("R9", "issue during flush", 32'(issue_valid), 32'd0);
        check("R9", "deq during flush", 32'(deq_count), 32'd0);
        @(negedge clk); flush = 1'b0; fetch_valid = 1'b0; #1;
        check("R9", "ready after flush", 32'(fetch_ready), 32'd1);
        check("R9", "empty after flush", 32'(issue_valid), 32'd0);

        // R3 sweep against the bench queue model
        q_n = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            logic [3:0] m;
            logic rdy;
            int nd;
            @(negedge clk);
            fetch_valid = ($urandom_range(0, 1) == 1);
            flush = ($urandom_range(0, 31) == 0);
            for (int b = 0; b < 5; b++) unit_busy[b] = ($urandom_range(0, 3) == 0);
            for (int k = 0; k < 4; k++) begin
                set_slot(k, $urandom_range(0, 7), $urandom_range(0, 7),
                         $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 7));
            end
            tag_base = (tag_base + 4) % 256;
            #1;
            rdy = (q_n <= 2);
            m = model_issue(unit_busy, flush);
            check("R2", "sweep fetch_ready", 32'(fetch_ready), 32'(rdy));
            check("R3", "sweep issue_valid", 32'(issue_valid), 32'(m));
            check("R3", "sweep deq_count", 32'(deq_count), 32'($countones(m)));
            for (int k = 0; k < 4; k++)
                if (k < q_n) check("R2", "sweep slot tag", 32'(issue_tag[k*8 +: 8]), 32'(q_tag[k] % 256));
            if (flush) q_n = 0;
            else begin
                nd = $countones(m);
                for (int i = 0; i < q_n - nd; i++) begin
                    q_tag[i] = q_tag[i+nd]; q_cls[i] = q_cls[i+nd]; q_dst[i] = q_dst[i+nd];
                    q_den[i] = q_den[i+nd]; q_sa[i] = q_sa[i+nd]; q_sb[i] = q_sb[i+nd];
                end
                q_n -= nd;
                if (fetch_valid && rdy) begin
                    for (int k = 0; k < 4; k++) begin
                        q_tag[q_n] = int'(fetch_tag[k*8 +: 8]);
                        q_cls[q_n] = int'(fetch_cls[k*3 +: 3]);
                        q_dst[q_n] = int'(fetch_dst[k*5 +: 5]);
                        q_den[q_n] = int'(fetch_dst_en[k]);
                        q_sa[q_n]  = int'(fetch_src_a[k*5 +: 5]);
                        q_sb[q_n]  = int'(fetch_src_b[k*5 +: 5]);
                        q_n++;
                    end
                end
            end
        end
        @(negedge clk); fetch_valid = 1'b0; flush = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule